// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Pair

This block delays two one-bit sample streams by a programmable number of clock cycles. Each channel is a chain of bypassable stages whose lengths are powers of two. Every bit of the channel's delay code inserts or skips one stage, so a code of N bits gives any delay from 0 to 2^N-1 cycles on top of a fixed two-cycle minimum. The minimum comes from one input register and one output register.

A shared route bit picks how the two channels are used. In split routing the channels work on their own. In cascade routing, stream A runs through channel A and then channel B and leaves on output B, so the two codes add. Output A is then held low and input B is not used. A shared active-high mute input forces both outputs low at once and holds them there for as long as it is set. It is meant to hide the glitches that can appear while the codes are being changed.

Top module: `bdly_pair`

## Requirements
- R1: Stage k of a channel holds samples for 2^k cycles. Code bit k (bit 0 is the least significant) inserts that stage when it is 1 and bypasses it when it is 0.
- R2: For each of the 2^STAGES codes, a channel in split routing delays its input by exactly 2 + code cycles. The delay therefore rises strictly with the code.
- R3: With code 0, a channel adds only the fixed minimum latency of 2 cycles.
- R4: With cascade = 0, din_a reaches dout_a through code_a and din_b reaches dout_b through code_b. A pulse on one channel never appears on the other output.
- R5: With cascade = 1, din_a reaches dout_b after 4 + code_a + code_b cycles.
- R6: While cascade = 1, dout_a is low.
- R7: While mute = 1, dout_a and dout_b are low in the same cycle. When mute returns to 0, the delayed data shows again at once.
- R8: Reset (rst = 1, synchronous) clears every stage and pipeline register. After reset, the outputs stay low until data sampled after reset arrives.
- R9: With cascade = 1, din_b has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cascade | input | 1 | 0: split routing, 1: cascade A into B |
| mute | input | 1 | 1 forces both outputs low |
| code_a | input | STAGES | Delay code of channel A |
| code_b | input | STAGES | Delay code of channel B |
| din_a | input | 1 | Sample stream A |
| din_b | input | 1 | Sample stream B |
| dout_a | output | 1 | Delayed stream A, low in cascade routing |
| dout_b | output | 1 | Delayed stream B, or the cascaded result |

## Verification
The bench builds the block with STAGES = 6. Every code from 0 to 63 is then short enough to measure one after another, so the strict rise of latency with the code is checked over the whole code space and not on samples only. The same setting makes the longest cascaded path (4 + 63 + 63 cycles) and the clearing of fully loaded stages by reset cheap to observe. Single-bit codes isolate the weight of each stage.

// File: rtl/bdly_pkg.sv
package bdly_pkg;

  // Register stages on the fixed path of one channel: input and output.
  localparam int MIN_LAT = 2;

  typedef enum logic {
    ROUTE_SPLIT   = 1'b0,
    ROUTE_CASCADE = 1'b1
  } route_e;

  // Hold time of stage k in cycles.
  function automatic int stage_depth(input int k);
    return 1 << k;
  endfunction

  // Latency of one channel for a given code value.
  function automatic int chan_latency(input int code);
    return MIN_LAT + code;
  endfunction

  // Latency of the cascaded path.
  function automatic int cascade_latency(input int code_a, input int code_b);
    return chan_latency(code_a) + chan_latency(code_b);
  endfunction

endpackage

// File: rtl/bdly_stage.sv
module bdly_stage #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic sel,
  output logic dout
);

  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[DEPTH-2:0], din};
      end
    end
  endgenerate

  // The shift line runs on every cycle. The select only decides which tap is passed on.
  assign dout = sel ? sr[DEPTH-1] : din;

endmodule

// File: rtl/bdly_chan.sv
module bdly_chan
  import bdly_pkg::*;
#(
  parameter int STAGES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [STAGES-1:0] code,
  output logic              dout_q
);

  logic              in_q;
  logic [STAGES:0]   link;

  always_ff @(posedge clk) begin
    if (rst) in_q <= 1'b0;
    else     in_q <= din;
  end

  assign link[0] = in_q;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      bdly_stage #(.DEPTH(stage_depth(k))) u_stage (
        .clk  (clk),
        .rst  (rst),
        .din  (link[k]),
        .sel  (code[k]),
        .dout (link[k+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b0;
    else     dout_q <= link[STAGES];
  end

  // Cycles since reset, saturating, for the latency check below.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3: with every stage bypassed, a sample comes out two cycles after it was taken.
  p_min_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'(MIN_LAT) && $past(code) == '0) |-> (dout_q == $past(din, 2)));

endmodule

// File: rtl/bdly_pair.sv
module bdly_pair
  import bdly_pkg::*;
#(
  parameter int STAGES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cascade,
  input  logic              mute,
  input  logic [STAGES-1:0] code_a,
  input  logic [STAGES-1:0] code_b,
  input  logic              din_a,
  input  logic              din_b,
  output logic              dout_a,
  output logic              dout_b
);

  route_e route;
  logic   raw_a;
  logic   raw_b;
  logic   feed_b;

  assign route  = route_e'(cascade);
  assign feed_b = (route == ROUTE_CASCADE) ? raw_a : din_b;

  bdly_chan #(.STAGES(STAGES)) u_chan_a (
    .clk    (clk),
    .rst    (rst),
    .din    (din_a),
    .code   (code_a),
    .dout_q (raw_a)
  );

  bdly_chan #(.STAGES(STAGES)) u_chan_b (
    .clk    (clk),
    .rst    (rst),
    .din    (feed_b),
    .code   (code_b),
    .dout_q (raw_b)
  );

  // Forcing stays at the ports so that the cascade keeps using raw_a.
  assign dout_a = raw_a & ~mute & (route == ROUTE_SPLIT);
  assign dout_b = raw_b & ~mute;

  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  // R5: with zero codes, the cascaded path has four cycles of latency from din_a.
  p_cascade_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $past(cascade, 2) && $past(code_b) == '0 && $past(code_a, 3) == '0)
      |-> (raw_b == $past(din_a, 4)));

  p_idle_a_r6: assert property (@(posedge clk) disable iff (rst)
    cascade |-> !dout_a);

  p_mute_r7: assert property (@(posedge clk) disable iff (rst)
    mute |-> (!dout_a && !dout_b));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!raw_a && !raw_b));

endmodule

// File: tb/bdly_pair_bench.sv
module bdly_pair_bench;

  localparam int ST    = 6;
  localparam int MAXC  = (1 << ST) - 1;
  localparam int FLUSH = 2 * (MAXC + 4) + 4;
  localparam int NVEC  = 12;
  // Each row: cascade, source (0 = A, 1 = B), code_a, code_b
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 0, 0}, '{0, 1, 0, 0}, '{0, 0, 5, 40}, '{0, 1, 5, 40},
    '{0, 0, 63, 0}, '{0, 1, 0, 63}, '{0, 0, 42, 21}, '{0, 1, 42, 21},
    '{1, 0, 0, 0}, '{1, 0, 63, 63}, '{1, 0, 1, 62}, '{1, 0, 37, 9}
  };

  logic          clk = 1'b0;
  logic          rst, cascade, mute, din_a, din_b;
  logic [ST-1:0] code_a, code_b;
  logic          dout_a, dout_b;
  int            n_run = 0;
  int            n_fail = 0;

  always #10 clk = ~clk;

  bdly_pair #(.STAGES(ST)) u_bdly_pair (
    .clk(clk), .rst(rst), .cascade(cascade), .mute(mute),
    .code_a(code_a), .code_b(code_b), .din_a(din_a), .din_b(din_b),
    .dout_a(dout_a), .dout_b(dout_b)
  );

  function automatic int want_lat(input int cas, input int src, input int ca, input int cb);
    if (cas != 0) return ca + cb + 4;
    return (src != 0) ? cb + 2 : ca + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input bit cas, input bit src, input int ca, input int cb,
                         output int lat, output bit other_hi, output bit wide);
    logic watched, other;
    cascade = cas; code_a = ST'(ca); code_b = ST'(cb); din_a = 0; din_b = 0;
    repeat (FLUSH) @(negedge clk);
    if (src) din_b = 1; else din_a = 1;
    @(negedge clk);
    din_a = 0; din_b = 0;
    lat = -1; other_hi = 0; wide = 0;
    for (int k = 1; k <= 300; k++) begin
      watched = (cas || src) ? dout_b : dout_a;
      other   = (cas || src) ? dout_a : dout_b;
      if (other) other_hi = 1;
      if (watched) begin
        if (lat < 0) lat = k; else wide = 1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, prev;
    bit oh, wd;
    rst = 1; cascade = 0; mute = 0; din_a = 0; din_b = 0; code_a = '0; code_b = '0;
    repeat (3) @(negedge clk);
    chk(dout_a == 0 && dout_b == 0, "R8 outputs low in reset", {dout_a, dout_b}, 0);
    rst = 0;

    // Table of routing/code vectors
    for (int v = 0; v < NVEC; v++) begin
      measure(VEC[v][0] != 0, VEC[v][1] != 0, VEC[v][2], VEC[v][3], lat, oh, wd);
      chk(lat == want_lat(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]),
          (VEC[v][0] != 0) ? "R5 cascade latency" : "R4 split latency",
          lat, want_lat(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]));
      chk(!oh, (VEC[v][0] != 0) ? "R6 dout_a idle in cascade" : "R4 no crosstalk", oh, 0);
      chk(!wd, "R4 pulse width one cycle", wd, 0);
    end

    // R3: code 0 gives the bare minimum
    measure(0, 0, 0, 17, lat, oh, wd);
    chk(lat == 2, "R3 minimum latency", lat, 2);

    // R1: each stage alone, on channel B with a busy channel A code
    for (int k = 0; k < ST; k++) begin
      measure(0, 1, 33, 1 << k, lat, oh, wd);
      chk(lat == 2 + (1 << k), "R1 single stage weight", lat, 2 + (1 << k));
    end

    // R2: full sweep, strictly rising
    prev = 1;
    for (int c = 0; c <= MAXC; c++) begin
      measure(0, 0, c, 0, lat, oh, wd);
      chk(lat == c + 2 && lat > prev, "R2 latency sweep", lat, c + 2);
      prev = lat;
    end

    // R7: mute on steady data
    cascade = 0; code_a = '0; code_b = '0; din_a = 1; din_b = 1;
    repeat (5) @(negedge clk);
    chk(dout_a && dout_b, "R7 data passes unmuted", {dout_a, dout_b}, 3);
    mute = 1; #1;
    chk(!dout_a && !dout_b, "R7 mute forces low", {dout_a, dout_b}, 0);
    @(negedge clk);
    chk(!dout_a && !dout_b, "R7 mute holds low", {dout_a, dout_b}, 0);
    mute = 0; #1;
    chk(dout_a && dout_b, "R7 release restores data", {dout_a, dout_b}, 3);
    din_a = 0; din_b = 0;
    mute = 1;
    measure(0, 0, 3, 0, lat, oh, wd);
    chk(lat == -1, "R7 muted pulse hidden", lat, -1);
    mute = 0;

    // R9: din_b ignored in cascade
    cascade = 1; code_a = '0; code_b = '0; din_a = 0;
    repeat (FLUSH) @(negedge clk);
    oh = 0;
    for (int k = 0; k < 150; k++) begin
      din_b = k[0] | k[2];
      @(negedge clk);
      if (dout_a || dout_b) oh = 1;
    end
    din_b = 0;
    chk(!oh, "R9 din_b ignored in cascade", oh, 0);

    // R8: stages loaded with ones are cleared by reset
    cascade = 0; code_a = ST'(MAXC); din_a = 1;
    repeat (FLUSH) @(negedge clk);
    chk(dout_a == 1, "R8 stages preloaded", dout_a, 1);
    rst = 1;
    repeat (2) @(negedge clk);
    din_a = 0; rst = 0;
    oh = 0;
    for (int k = 0; k < MAXC + 10; k++) begin
      @(negedge clk);
      if (dout_a) oh = 1;
    end
    chk(!oh, "R8 reset clears stages", oh, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule